// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves incoming frames into receive buffers. The buffers are described by a circular ring of descriptors held in an on-chip table. Each descriptor has two 32-bit words. The address word gives the base of a buffer. The flags word carries an ownership bit and a length field. Software fills in descriptors that the hardware owns, with the buffer capacity in the length field.

When a frame starts, the engine looks at the descriptor under its ring index. If the hardware owns that descriptor, the frame's bytes go out on a simple buffer-write port. At the end of the frame the engine writes the received length and status back into the flags word, clears ownership, raises a one-cycle interrupt pulse and moves the index on. The index wraps after the last entry of the selected ring length. If the descriptor belongs to software, the whole frame is dropped and a missed-frame counter steps.

A software-side port reads and writes any descriptor word. A testbench uses it to preload descriptors and to inspect them after write-back. Frames arrive as a byte stream marked with start-of-frame and end-of-frame flags. A DMA-enable input gates all receive activity.

Top module: `rx_desc_ring_engine`

## Requirements
- R1: After reset the ring index and the missed-frame count are 0, and neither the interrupt nor the buffer write strobe is asserted.
- R2: A frame that lands on a hardware-owned descriptor (flags bit 31 set) has byte k written to buffer address base+k, for k from 0. The first write appears the cycle after the first byte is accepted.
- R3: At the end of a frame with no overflow, the flags word becomes 0 except bits 13:0, which hold the received byte count. Ownership (bit 31) is therefore cleared, and the address word is left unchanged.
- R4: If a frame is longer than the capacity in bits 13:0 of the flags word, only that many bytes are written. The length field then holds the capacity, and overflow bit 30 is set.
- R5: If the descriptor is not hardware-owned, the frame causes no buffer writes and no interrupt. The descriptor and ring index stay unchanged, and the missed-frame count rises by one.
- R6: While the DMA-enable input is low, a frame is ignored entirely: no writes, no write-back, no index or counter change.
- R7: The ring length is 32, 64, 128 or 256 descriptors for ring code 0, 1, 2 or 3. The index advances by one per completed frame and returns to 0 after the last entry.
- R8: Each write-back is followed by exactly one cycle of interrupt, in the cycle after the end-of-frame byte is accepted.
- R9: Software writes to an address word have bits 5:0 forced to zero. A software read (select 0 = flags word, 1 = address word) returns data in the cycle after the request.
- R10: Bytes with the valid strobe that arrive outside a frame, without a start flag, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dma_en | input | 1 | Receive DMA enable |
| cfg_ring_code | input | 2 | Ring length select |
| rx_valid | input | 1 | Byte valid |
| rx_sop | input | 1 | First byte of frame |
| rx_eop | input | 1 | Last byte of frame |
| rx_data | input | 8 | Frame byte |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | 32 | Buffer write address |
| buf_wdata | output | 8 | Buffer write byte |
| sw_en | input | 1 | Software access request |
| sw_we | input | 1 | Software write (else read) |
| sw_sel | input | 1 | 0 flags word, 1 address word |
| sw_idx | input | 8 | Descriptor index |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data |
| ring_idx | output | 8 | Current ring index |
| missed_cnt | output | 16 | Dropped-frame count |
| irq | output | 1 | Write-back pulse |

## Verification
The wrap point is the hardest case to reach. The ring index only moves after a completed frame, and every completion consumes an owned descriptor. To reach it, the stimulus keeps re-arming descriptors through the software port and streams enough short frames to walk the whole 32-entry ring. It then switches to the 64-entry code and re-arms again. This shows that index 32 is passed without wrapping and that the return to 0 comes only after entry 63. The truncation and not-owned cases are set up by preloading specific descriptors with a small capacity or with ownership clear. The scoreboard then shows that no surplus or stray buffer write appears.

// File: rtl/rx_ring_pkg.sv
// Package: shared constants and types for the receive descriptor ring engine.
// Assumes a 32-bit flags word with ownership at bit 31, overflow at bit 30
// and the length field in the low LEN_W bits.
package rx_ring_pkg;
    localparam int OWN_BIT  = 31;
    localparam int OVF_BIT  = 30;
    localparam int LEN_W    = 14;
    localparam int WORD_W   = 32;
    localparam int ALIGN_W  = 6;
    localparam int MIN_RING = 32;
    localparam int CODE_W   = 2;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_RECV = 2'd1,
        RX_DROP = 2'd2
    } rx_state_t;
endpackage

// File: rtl/rx_desc_mem.sv
// Descriptor table: one flags word and one address word per entry.
// The engine side reads combinationally at its index and writes flags back;
// the software side has synchronous read and write. On a same-entry flags
// write collision the engine write wins. Address writes are aligned.
module rx_desc_mem
    import rx_ring_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  eng_idx,
    output logic [WORD_W-1:0] eng_flags,
    output logic [WORD_W-1:0] eng_addr,
    input  logic              eng_we,
    input  logic [WORD_W-1:0] eng_wflags,
    input  logic              sw_en,
    input  logic              sw_we,
    input  logic              sw_sel,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] sw_rdata
);
    logic [WORD_W-1:0] flags_q [DEPTH];
    logic [WORD_W-1:0] addr_q  [DEPTH];

    // Engine-side lookup of the descriptor under the ring index.
    always_comb begin
        eng_flags = flags_q[eng_idx];
        eng_addr  = addr_q[eng_idx];
    end

    // Table updates: software writes, then engine write-back (wins last).
    always_ff @(posedge clk) begin
        if (sw_en && sw_we) begin
            if (sw_sel) addr_q[sw_idx]  <= {sw_wdata[WORD_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
            else        flags_q[sw_idx] <= sw_wdata;
        end
        if (eng_we) flags_q[eng_idx] <= eng_wflags;
    end

    // Software read data register, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)                sw_rdata <= '0;
        else if (sw_en && !sw_we)  sw_rdata <= sw_sel ? addr_q[sw_idx] : flags_q[sw_idx];
    end

    // R3: a write-back from the frame engine never leaves ownership set.
    p_wb_clears_own_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> !eng_wflags[OWN_BIT]);
endmodule

// File: rtl/rx_ring_ptr.sv
// Ring index register. Advances once per completed frame and wraps to zero
// after the last entry of the ring length chosen by the ring code
// (MIN_RING shifted left by the code). Assumes the code is changed only
// while the index lies inside the new ring.
module rx_ring_ptr
    import rx_ring_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ring_code,
    input  logic              adv,
    output logic [IDX_W-1:0]  cur_idx
);
    logic [IDX_W-1:0] last_idx;

    // Last valid index of the selected ring.
    always_comb last_idx = IDX_W'((MIN_RING << ring_code) - 1);

    // Index update with wraparound.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_idx <= '0;
        else if (adv)    cur_idx <= (cur_idx == last_idx) ? '0 : cur_idx + 1'b1;
    end

    // R7: without a completion the index does not move.
    p_idx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cur_idx));
endmodule

// File: rtl/rx_frame_fsm.sv
// Frame engine. At a start-of-frame byte it checks ownership of the current
// descriptor: when owned it streams bytes to buf_* up to the capacity, then
// produces a write-back flags word and an advance strobe at end of frame;
// when not owned it swallows the frame and counts it as missed. Registered
// buffer-write and interrupt outputs. Assumes frames are well formed.
module rx_frame_fsm
    import rx_ring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic [WORD_W-1:0] desc_flags,
    input  logic [ADDR_W-1:0] desc_addr,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_wdata,
    output logic              wb_en,
    output logic [WORD_W-1:0] wb_flags,
    output logic [CNT_W-1:0]  miss_cnt,
    output logic              irq
);
    rx_state_t        st_q;
    logic [LEN_W-1:0] cnt_q, cap_q;
    logic [ADDR_W-1:0] base_q;
    logic             start, owned, active, store, ovf;
    logic [LEN_W-1:0] beat_off, beat_cap, total, stored_len;
    logic [ADDR_W-1:0] beat_base;

    // Per-beat decode: which descriptor context applies and what to store.
    always_comb begin
        start = (st_q == RX_IDLE) && in_valid && in_sop && dma_en;
        owned = desc_flags[OWN_BIT];
        if (st_q == RX_RECV) begin
            beat_off  = cnt_q;
            beat_cap  = cap_q;
            beat_base = base_q;
        end else begin
            beat_off  = '0;
            beat_cap  = desc_flags[LEN_W-1:0];
            beat_base = desc_addr;
        end
        active     = (start && owned) || ((st_q == RX_RECV) && in_valid);
        store      = active && (beat_off < beat_cap);
        total      = (&beat_off) ? beat_off : beat_off + 1'b1;
        ovf        = total > beat_cap;
        stored_len = ovf ? beat_cap : total;
        wb_en      = active && in_eop;
        wb_flags   = '0;
        wb_flags[OVF_BIT]     = ovf;
        wb_flags[LEN_W-1:0]   = stored_len;
    end

    // Frame state and captured descriptor context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RX_IDLE;
            cnt_q  <= '0;
            cap_q  <= '0;
            base_q <= '0;
        end else begin
            case (st_q)
                RX_IDLE: if (start && !in_eop) begin
                    st_q   <= owned ? RX_RECV : RX_DROP;
                    cnt_q  <= total;
                    cap_q  <= beat_cap;
                    base_q <= beat_base;
                end
                RX_RECV: if (in_valid) begin
                    cnt_q <= total;
                    if (in_eop) st_q <= RX_IDLE;
                end
                RX_DROP: if (in_valid && in_eop) st_q <= RX_IDLE;
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    // Registered buffer write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_we    <= 1'b0;
            buf_addr  <= '0;
            buf_wdata <= '0;
        end else begin
            buf_we    <= store;
            buf_addr  <= beat_base + {{(ADDR_W-LEN_W){1'b0}}, beat_off};
            buf_wdata <= in_data;
        end
    end

    // Interrupt pulse after write-back and missed-frame counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            miss_cnt <= '0;
        end else begin
            irq <= wb_en;
            if (start && !owned) miss_cnt <= miss_cnt + 1'b1;
        end
    end

    // R5: a frame being dropped produces no buffer write.
    p_drop_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_DROP) |=> !buf_we);
    // R5: the missed count only ever moves up by one.
    p_miss_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_cnt != $past(miss_cnt)) |-> (miss_cnt == $past(miss_cnt) + 1'b1));
    // R6: idle with DMA disabled starts nothing.
    p_dma_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == RX_IDLE) && !dma_en) |=> (!buf_we && $stable(miss_cnt) && !irq));
endmodule

// File: rtl/rx_desc_ring_engine.sv
// Top: receive descriptor ring engine. Joins the descriptor table, the
// ring index and the frame engine. Software port and ring engine share
// the table; software must not rewrite the entry under the ring index
// while a frame is in progress.
module rx_desc_ring_engine
    import rx_ring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    localparam int DEPTH = MIN_RING << ((1 << CODE_W) - 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dma_en,
    input  logic [CODE_W-1:0] cfg_ring_code,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [DATA_W-1:0] rx_data,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [DATA_W-1:0] buf_wdata,
    input  logic              sw_en,
    input  logic              sw_we,
    input  logic              sw_sel,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] sw_rdata,
    output logic [IDX_W-1:0]  ring_idx,
    output logic [CNT_W-1:0]  missed_cnt,
    output logic              irq
);
    logic [WORD_W-1:0] desc_flags, desc_addr_w, wb_flags;
    logic              wb_en;

    rx_desc_mem #(.DEPTH(DEPTH)) mem_i (
        .clk(clk), .rst_n(rst_n),
        .eng_idx(ring_idx), .eng_flags(desc_flags), .eng_addr(desc_addr_w),
        .eng_we(wb_en), .eng_wflags(wb_flags),
        .sw_en(sw_en), .sw_we(sw_we), .sw_sel(sw_sel), .sw_idx(sw_idx),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
    );

    rx_ring_ptr #(.IDX_W(IDX_W)) ptr_i (
        .clk(clk), .rst_n(rst_n), .ring_code(cfg_ring_code),
        .adv(wb_en), .cur_idx(ring_idx)
    );

    rx_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .dma_en(cfg_dma_en),
        .in_valid(rx_valid), .in_sop(rx_sop), .in_eop(rx_eop), .in_data(rx_data),
        .desc_flags(desc_flags), .desc_addr(desc_addr_w[ADDR_W-1:0]),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .wb_en(wb_en), .wb_flags(wb_flags), .miss_cnt(missed_cnt), .irq(irq)
    );

    // R8: every interrupt pulse coincides with a moved ring index.
    p_irq_moves_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ring_idx != $past(ring_idx)));
endmodule

// File: tb/rx_desc_ring_engine_tb_top.sv
// Scoreboard bench: the frame driver queues expected buffer writes, a
// monitor pops and compares them as the engine emits them.
module rx_desc_ring_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dma_en = 1'b0;
    logic [1:0]  cfg_ring_code = 2'd0;
    logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        buf_we;
    logic [31:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic        sw_en = 1'b0, sw_we = 1'b0, sw_sel = 1'b0;
    logic [7:0]  sw_idx = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic [7:0]  ring_idx;
    logic [15:0] missed_cnt;
    logic        irq;

    int n_chk = 0, n_bad = 0, irq_seen = 0, irq_exp = 0;
    logic [39:0] exp_q [$];
    logic [31:0] rd;

    always #2 clk = ~clk;

    rx_desc_ring_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_dma_en(cfg_dma_en), .cfg_ring_code(cfg_ring_code),
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .sw_en(sw_en), .sw_we(sw_we), .sw_sel(sw_sel), .sw_idx(sw_idx),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .ring_idx(ring_idx), .missed_cnt(missed_cnt), .irq(irq)
    );

    function automatic logic [31:0] base_of(int i);
        return 32'h0010_0000 + i * 32'h800;
    endfunction

    task automatic check(bit ok, string tag, logic [39:0] act, logic [39:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: compare buffer writes against the queue, count interrupt cycles.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) irq_seen++;
            if (buf_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2/R5/R6/R10 unexpected buffer write", {buf_addr, buf_wdata}, 40'h0);
                end else begin
                    logic [39:0] e;
                    e = exp_q.pop_front();
                    check({buf_addr, buf_wdata} == e, "R2 buffer write", {buf_addr, buf_wdata}, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 40'h0, 40'h1);
        finish_run();
    end

    task automatic sw_write(int idx, bit sel, logic [31:0] d);
        @(negedge clk);
        sw_en = 1; sw_we = 1; sw_sel = sel; sw_idx = 8'(idx); sw_wdata = d;
        @(negedge clk);
        sw_en = 0; sw_we = 0;
    endtask

    task automatic sw_read(int idx, bit sel, output logic [31:0] d);
        @(negedge clk);
        sw_en = 1; sw_we = 0; sw_sel = sel; sw_idx = 8'(idx);
        @(negedge clk);
        sw_en = 0;
        d = sw_rdata;
    endtask

    task automatic arm(int idx, int cap, bit own);
        sw_write(idx, 1'b1, base_of(idx) | 32'h25);
        sw_write(idx, 1'b0, {own, 17'h0, 14'(cap)});
    endtask

    // Driver: stream one frame; queue expected writes if it will be stored.
    task automatic send_frame(int idx, int len, int cap, bit stored);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1; rx_sop = (k == 0); rx_eop = (k == len - 1);
            rx_data = 8'(idx * 13 + k * 3 + 1);
            if (stored && k < cap) exp_q.push_back({base_of(idx) + 32'(k), rx_data});
        end
        if (stored) irq_exp++;
        @(negedge clk);
        rx_valid = 0; rx_sop = 0; rx_eop = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ring_idx == 0 && missed_cnt == 0 && !irq && !buf_we, "R1 reset state",
              {ring_idx, missed_cnt, 6'b0, irq, buf_we}, 40'h0);
        rst_n = 1;
        for (int i = 0; i < 32; i++) arm(i, 1600, 1'b1);
        arm(1, 4, 1'b1);
        arm(2, 3, 1'b0);
        sw_read(5, 1'b1, rd);
        check(rd == base_of(5), "R9 address aligned on write", rd, base_of(5));

        send_frame(0, 5, 1600, 1'b0);
        check(ring_idx == 0 && missed_cnt == 0, "R6 frame ignored with DMA off", ring_idx, 0);
        sw_read(0, 1'b0, rd);
        check(rd == 32'h8000_0640, "R6 descriptor untouched", rd, 32'h8000_0640);

        cfg_dma_en = 1;
        send_frame(0, 5, 1600, 1'b1);
        sw_read(0, 1'b0, rd);
        check(rd == 32'h0000_0005, "R3 write-back length, ownership cleared", rd, 32'h5);
        sw_read(0, 1'b1, rd);
        check(rd == base_of(0), "R3 address word unchanged", rd, base_of(0));
        check(ring_idx == 1, "R7 index advanced", ring_idx, 1);
        check(irq_seen == 1, "R8 one interrupt cycle", irq_seen, 1);

        for (int k = 0; k < 3; k++) begin
            @(negedge clk); rx_valid = 1; rx_sop = 0; rx_eop = (k == 2); rx_data = 8'hEE;
        end
        @(negedge clk); rx_valid = 0; rx_eop = 0;
        repeat (2) @(negedge clk);
        check(ring_idx == 1 && irq_seen == 1, "R10 stray bytes ignored", ring_idx, 1);

        send_frame(1, 7, 4, 1'b1);
        sw_read(1, 1'b0, rd);
        check(rd == 32'h4000_0004, "R4 truncated with overflow flag", rd, 32'h4000_0004);

        send_frame(2, 3, 3, 1'b0);
        check(missed_cnt == 1, "R5 missed count", missed_cnt, 1);
        check(ring_idx == 2, "R5 index held", ring_idx, 2);
        check(irq_seen == 2, "R5 no interrupt on drop", irq_seen, 2);
        sw_read(2, 1'b0, rd);
        check(rd == 32'h0000_0003, "R5 descriptor untouched", rd, 32'h3);
        arm(2, 1600, 1'b1);
        send_frame(2, 1, 1600, 1'b1);
        sw_read(2, 1'b0, rd);
        check(rd == 32'h0000_0001, "R3 single-byte frame", rd, 32'h1);

        for (int i = 3; i < 32; i++) send_frame(i, 2, 1600, 1'b1);
        check(ring_idx == 0, "R7 wrap after 32 with code 0", ring_idx, 0);

        cfg_ring_code = 2'd1;
        for (int i = 0; i < 64; i++) arm(i, 1600, 1'b1);
        for (int i = 0; i < 32; i++) send_frame(i, 2, 1600, 1'b1);
        check(ring_idx == 32, "R7 no wrap at 32 with code 1", ring_idx, 32);
        for (int i = 32; i < 64; i++) send_frame(i, 2, 1600, 1'b1);
        check(ring_idx == 0, "R7 wrap after 64 with code 1", ring_idx, 0);

        check(exp_q.size() == 0, "R2 all expected writes seen", exp_q.size(), 0);
        check(irq_seen == irq_exp, "R8 interrupt count", irq_seen, irq_exp);
        check(missed_cnt == 1, "R5 final missed count", missed_cnt, 1);
        finish_run();
    end
endmodule